// File: doc/BRIEF.md
# Stereo De-Emphasis Shelving Filter

This block applies the classic 50 µs / 15 µs de-emphasis response to a stereo stream of signed 24-bit audio samples. It is a first-order IIR shelf. Low frequencies pass at unity gain. Above roughly 10.6 kHz the response settles about 10 dB lower. The pole corner sits near 3.18 kHz. The fixed-point coefficients come from a bilinear mapping at a 44.1 kHz sample rate. The response scales with the sample rate, so the curve is only accurate at that rate.

A sample pair enters with a one-cycle valid strobe. The filtered pair leaves one clock later with its own valid. One static enable selects the filter or an exact pass-through. A two-bit speed-mode input also gates the filter, which runs only in single-speed operation. Whenever the filter is not running, its history is cleared. A later re-enable therefore begins from silence rather than from stale state.

Top module: `deemph_shelf`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. `out_left`/`out_right` change only on a clock where `out_valid` rises with a new result, and hold their value otherwise. After reset, `out_valid` and both outputs are 0.
- R2: While filtering, each channel computes acc = 1800992·x[n] − 250418·x[n−1] + 2643730·y[n−1] + 2097152, then y[n] = acc arithmetically shifted right by 22. These are the coefficients in signed Q2.22 with round-half-up.
- R3: Each filtered result is clamped to the signed 24-bit range [−8388608, 8388607] before it is output and stored as y[n−1]. Accumulation uses at least 48 bits, so full-scale inputs never wrap.
- R4: With `deemph_en` = 0, each output is bit-identical to the input sample of the previous valid cycle.
- R5: `speed_mode` encoding: 0 = single speed, 1 = double speed, 2 and 3 = quad speed. The filter runs only when `speed_mode` = 0 and `deemph_en` = 1. Any other speed value gives bit-exact bypass.
- R6: Left and right keep separate history and never influence each other. Both channels advance on the same valid strobe.
- R7: On every clock where the filter is not running, both channels' x[n−1] and y[n−1] are cleared to 0. The first result after a re-enable is therefore round(1800992·x/2^22).
- R8: A constant input settles to within 2 LSB of the same value, giving 0 dB gain at DC.
- R9: A full-rate alternating input of amplitude A settles to an output amplitude of about 0.30·A, the −10 dB shelf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deemph_en | input | 1 | 1 = filter, 0 = bypass |
| speed_mode | input | 2 | 0 single, 1 double, 2/3 quad |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
The assertions check the per-cycle contracts on every clock:
- the one-cycle valid delay and the output hold between results;
- exact pass-through whenever the enable is low or the speed mode is not single;
- cleared history after every bypassed clock.

The arithmetic needs the bench's scenarios. A scoreboard model checks the rounding and the feedback across impulses, pseudo-random streams and full-scale steps. Separate runs show the unity DC settling, the −10 dB Nyquist shelf, channel isolation and the clean restart after re-enable.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_QUAD_X = 2'd3
  } speed_e;

  localparam int NUM_CH = 2;

  // Fixed-point coefficients, signed Q2.22, bilinear mapping at 44.1 kHz
  localparam int COEF_B0 = 1800992;
  localparam int COEF_B1 = -250418;
  localparam int COEF_FB = 2643730;   // negated a1: feedback term is added

endpackage

// File: rtl/deemph_mode_gate.sv
module deemph_mode_gate
  import deemph_pkg::*;
(
  input  logic       enable,
  input  logic [1:0] speed,
  output logic       run
);

  speed_e spd;

  always_comb begin
    spd = speed_e'(speed);
    run = 1'b0;
    if (enable) begin
      case (spd)
        SPD_SINGLE: run = 1'b1;
        default:    run = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/deemph_channel.sv
module deemph_channel #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int FRAC_W = 22,
  parameter int ACC_W  = 52,
  parameter int B0     = 1800992,
  parameter int B1     = -250418,
  parameter int FB     = 2643730
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_in,
  output logic signed [DATA_W-1:0] smp_out,
  output logic signed [DATA_W-1:0] hist_x,
  output logic signed [DATA_W-1:0] hist_y
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [COEF_W-1:0] C_B0 = COEF_W'(B0);
  localparam logic signed [COEF_W-1:0] C_B1 = COEF_W'(B1);
  localparam logic signed [COEF_W-1:0] C_FB = COEF_W'(FB);
  localparam logic signed [ACC_W-1:0] RND  =
    {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] VMAX =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] VMIN =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] mul_ext(
    input logic signed [DATA_W-1:0] s,
    input logic signed [COEF_W-1:0] c
  );
    logic signed [PROD_W-1:0] p;
    p = s * c;
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  function automatic logic signed [ACC_W-1:0] shelf_acc(
    input logic signed [DATA_W-1:0] x0,
    input logic signed [DATA_W-1:0] x1,
    input logic signed [DATA_W-1:0] y1
  );
    return mul_ext(x0, C_B0) + mul_ext(x1, C_B1) + mul_ext(y1, C_FB) + RND;
  endfunction

  function automatic logic signed [DATA_W-1:0] clamp(
    input logic signed [ACC_W-1:0] a
  );
    logic signed [ACC_W-1:0] r;
    if (a > VMAX)      r = VMAX;
    else if (a < VMIN) r = VMIN;
    else               r = a;
    return r[DATA_W-1:0];
  endfunction

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [DATA_W-1:0] y_new;

  always_comb begin
    acc    = shelf_acc(smp_in, hist_x, hist_y);
    scaled = acc >>> FRAC_W;
    y_new  = clamp(scaled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_x  <= '0;
      hist_y  <= '0;
      smp_out <= '0;
    end else begin
      if (!run) begin
        hist_x <= '0;
        hist_y <= '0;
      end else if (smp_vld) begin
        hist_x <= smp_in;
        hist_y <= y_new;
      end
      if (smp_vld) smp_out <= run ? y_new : smp_in;
    end
  end

endmodule

// File: rtl/deemph_shelf.sv
module deemph_shelf
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int FRAC_W = 22,
  parameter int ACC_W  = 52
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     deemph_en,
  input  logic [1:0]               speed_mode,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);

  localparam int HIST_W = 2 * NUM_CH * DATA_W;

  logic                     filt_on;
  logic signed [DATA_W-1:0] ch_in   [NUM_CH];
  logic signed [DATA_W-1:0] ch_out  [NUM_CH];
  logic signed [DATA_W-1:0] ch_hx   [NUM_CH];
  logic signed [DATA_W-1:0] ch_hy   [NUM_CH];
  logic [HIST_W-1:0]        hist_flat;

  deemph_mode_gate u_gate (
    .enable (deemph_en),
    .speed  (speed_mode),
    .run    (filt_on)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    deemph_channel #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W),
      .ACC_W  (ACC_W),
      .B0     (COEF_B0),
      .B1     (COEF_B1),
      .FB     (COEF_FB)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (filt_on),
      .smp_vld (in_valid),
      .smp_in  (ch_in[c]),
      .smp_out (ch_out[c]),
      .hist_x  (ch_hx[c]),
      .hist_y  (ch_hy[c])
    );
    assign hist_flat[(2*c)*DATA_W +: DATA_W]   = ch_hx[c];
    assign hist_flat[(2*c+1)*DATA_W +: DATA_W] = ch_hy[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/deemph_shelf_chk.sv
module deemph_shelf_chk #(
  parameter int DATA_W = 24,
  parameter int HIST_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              deemph_en,
  input logic [1:0]        speed_mode,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              filt_on,
  input logic [HIST_W-1:0] hist_flat
);

  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> out_valid == $past(in_valid));

  // R1
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && !out_valid |-> $stable(out_left) && $stable(out_right));

  // R4
  enable_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && out_valid && !$past(deemph_en)
      |-> out_left == $past(in_left) && out_right == $past(in_right));

  // R5
  speed_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && out_valid && ($past(speed_mode) != 2'd0)
      |-> out_left == $past(in_left) && out_right == $past(in_right));

  // R7
  history_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$past(filt_on) |-> hist_flat == '0);

endmodule

bind deemph_shelf deemph_shelf_chk #(
  .DATA_W (DATA_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .deemph_en  (deemph_en),
  .speed_mode (speed_mode),
  .in_valid   (in_valid),
  .in_left    (in_left),
  .in_right   (in_right),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right),
  .filt_on    (filt_on),
  .hist_flat  (hist_flat)
);

// File: tb/deemph_shelf_bench.sv
module deemph_shelf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        deemph_en = 1'b0;
  logic [1:0]  speed_mode = 2'd0;
  logic        in_valid = 1'b0;
  logic signed [23:0] in_left = '0;
  logic signed [23:0] in_right = '0;
  logic        out_valid;
  logic signed [23:0] out_left;
  logic signed [23:0] out_right;

  always #4 clk = ~clk;

  deemph_shelf u_deemph_shelf (
    .clk(clk), .rst_n(rst_n), .deemph_en(deemph_en), .speed_mode(speed_mode),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  typedef struct { int l; int r; string req; } exp_t;
  exp_t sb_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int ml_x1 = 0, ml_y1 = 0, mr_x1 = 0, mr_y1 = 0;
  int last_l = 0, last_r = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model restated from the requirement: integer Q2.22, round half up, clamp
  function automatic int model(input int x, input int x1, input int y1);
    longint t;
    t = longint'(x) * 1800992 - longint'(x1) * 250418 + longint'(y1) * 2643730;
    t = (t + 2097152) >>> 22;
    if (t > 8388607)  t = 8388607;
    if (t < -8388608) t = -8388608;
    return int'(t);
  endfunction

  function automatic bit running();
    return deemph_en && (speed_mode == 2'd0);
  endfunction

  task automatic set_mode(input bit en, input logic [1:0] spd);
    @(negedge clk);
    in_valid   = 1'b0;
    deemph_en  = en;
    speed_mode = spd;
    if (!(en && spd == 2'd0)) begin
      ml_x1 = 0; ml_y1 = 0; mr_x1 = 0; mr_y1 = 0;
    end
    @(negedge clk);
  endtask

  task automatic send(input int l, input int r, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 24'(l);
    in_right = 24'(r);
    if (running()) begin
      e.l = model(l, ml_x1, ml_y1);
      e.r = model(r, mr_x1, mr_y1);
      ml_x1 = l; ml_y1 = e.l; mr_x1 = r; mr_y1 = e.r;
    end else begin
      e.l = l; e.r = r;
    end
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: scoreboard pop and compare
  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(out_left == e.l, {e.req, " left"}, out_left, e.l);
        check(out_right == e.r, {e.req, " right"}, out_right, e.r);
      end
      last_l = out_left;
      last_r = out_right;
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(out_left == 0 && out_right == 0, "R1 reset data", out_left, 0);

    // R4 bypass with enable low, pseudo-random data
    set_mode(1'b0, 2'd0);
    seed = 7;
    for (int i = 0; i < 20; i++) begin
      seed = seed * 1103515245 + 12345;
      send(int'($signed(seed[30:7])), int'($signed(seed[29:6])), "R4 enable-off bypass");
    end
    drain();

    // R7 first result after enable, R6 isolation (right stays 0), R2 impulse tail
    set_mode(1'b1, 2'd0);
    send(1000000, 0, "R7 first-after-enable");
    check(ml_y1 == 429390, "R7 model first result", ml_y1, 429390);
    for (int i = 0; i < 15; i++) send(0, 0, "R2 impulse tail / R6 isolation");
    drain();
    check(last_r == 0, "R6 right untouched by left", last_r, 0);

    // R2 pseudo-random stream, back-to-back
    seed = 99;
    for (int i = 0; i < 40; i++) begin
      seed = seed * 1103515245 + 12345;
      send(int'($signed(seed[30:7])), int'($signed(seed[27:4])), "R2 random stream");
    end
    drain();

    // R1 outputs hold while no valid
    idle(5);
    check(out_left == last_l && out_right == last_r, "R1 hold", out_left, last_l);

    // R3 full-scale steps
    for (int i = 0; i < 12; i++) send(8388607, -8388608, "R3 full-scale");
    for (int i = 0; i < 12; i++) send((i % 2) ? 8388607 : -8388608,
                                      (i % 3) ? -8388608 : 8388607, "R3 full-scale toggle");
    drain();
    check(last_l <= 8388607 && last_l >= -8388608, "R3 range", last_l, 0);

    // R8 DC unity: restart from cleared history
    set_mode(1'b0, 2'd0);
    set_mode(1'b1, 2'd0);
    for (int i = 0; i < 80; i++) send(2000000, -3000000, "R8 DC stream");
    drain();
    check(last_l - 2000000 <= 2 && 2000000 - last_l <= 2, "R8 DC left", last_l, 2000000);
    check(last_r + 3000000 <= 2 && -3000000 - last_r <= 2, "R8 DC right", last_r, -3000000);

    // R9 Nyquist shelf
    set_mode(1'b0, 2'd0);
    set_mode(1'b1, 2'd0);
    for (int i = 0; i < 80; i++) send((i % 2) ? 1000000 : -1000000, 0, "R9 Nyquist stream");
    drain();
    check((last_l > 290000 && last_l < 310000) || (last_l < -290000 && last_l > -310000),
          "R9 shelf amplitude", last_l, 300000);

    // R5 non-single speeds bypass, enable kept high
    for (int m = 1; m < 4; m++) begin
      set_mode(1'b1, 2'(m));
      seed = 31 * m;
      for (int i = 0; i < 6; i++) begin
        seed = seed * 1103515245 + 12345;
        send(int'($signed(seed[30:7])), int'($signed(seed[28:5])), "R5 speed bypass");
      end
      drain();
    end

    // R7 re-enable after filtering: history cleared
    set_mode(1'b1, 2'd0);
    for (int i = 0; i < 8; i++) send(500000, 400000, "R2 warm-up");
    drain();
    set_mode(1'b1, 2'd1);
    set_mode(1'b1, 2'd0);
    send(-1000000, 1000000, "R7 restart");
    drain();
    check(last_l == -429390 && last_r == 429390, "R7 restart result", last_l, -429390);

    check(sb_q.size() == 0, "R1 scoreboard empty", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule